// File: doc/BRIEF.md
# Line access switch state controller

This block is the digital control logic of a ten-switch subscriber line access device. Three mode inputs (ringing, test-in, test-out) choose which of five switch pairs is closed: the break pair, the ringing pair, the test-out pair, the test-in pair and the ringing-test pair. A hold input freezes the selected state so that the mode inputs can change freely while it is held. The block registers all five switch enables on one clock.

Three protective paths sit above the mode decode. An external override can pull the shutdown pin low to force all switches open. An over-temperature flag opens all switches and pulls the pin low, unless the pin is driven high. A battery monitor with two thresholds opens all switches when the battery is missing or too weak, and it waits for a stronger battery before it releases. The ringing pair never opens on command alone. It stays closed until the next ringing-current zero crossing, which gives make-before-break or break-before-make behaviour depending on the order of commands. The parameter `EXTENDED` selects a variant in which the ringing-test code also closes the test-out pair.

The bidirectional shutdown pin is modelled as two external drive inputs and one sensed level output. Analog comparators and the temperature sensor appear only as digital flags.

Top module: `line_switch_ctrl`

## Requirements
- R1: The mode code is {mode_ring, mode_tin, mode_tout}. 000 closes only break; 001 closes only test-out; 010 closes only test-in; 011 closes test-in and test-out; 100 closes only ringing; 110 closes only ringing-test; 101 and 111 open everything.
- R2: With EXTENDED=1, code 110 closes ringing-test and test-out together. All other codes decode as in R1.
- R3: While hold_en is 0 the mode inputs pass through. While hold_en is 1, the state uses the mode present in the last cycle hold_en was 0, and mode changes have no effect until hold_en returns to 0.
- R4: ovr_low=1 (pin forced low) opens every switch except a ringing pair still waiting for a zero crossing. This holds whatever the mode and hold_en are. While ovr_low is 1, sd_pin_level reads 0.
- R5: over_temp=1 with the pin floating opens every switch (ringing pair as in R7) and drives sd_pin_level to 0. With ovr_high=1, over_temp has no effect and sd_pin_level is 1.
- R6: A battery fault is set when bat_present=0 or bat_above_hi=1. It is cleared only when the battery is present, bat_above_hi=0 and bat_below_lo=1. Between the two thresholds the fault keeps its value. While the fault is set, all switches are open (ringing pair as in R7).
- R7: Once the ringing pair is closed, it stays closed until a cycle with ring_zc=1 arrives while ringing is no longer commanded. It opens on the clock edge that samples that ring_zc.
- R8: Reset (rst=1, synchronous) opens all switches, opens the hold latch with a stored code of 000, sets the battery fault and sets sd_pin_level to 1.
- R9: A mode or hold change reaches the outputs one clock later. The inputs ovr_low, ovr_high and over_temp take effect three clocks later, and the battery flags take effect four clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_ring | input | 1 | Ringing mode select |
| mode_tin | input | 1 | Test-in mode select |
| mode_tout | input | 1 | Test-out mode select |
| hold_en | input | 1 | 1 freezes the mode state, 0 passes it through |
| ovr_low | input | 1 | External driver pulls the shutdown pin low |
| ovr_high | input | 1 | External driver pulls the shutdown pin high (thermal off) |
| over_temp | input | 1 | Over-temperature flag |
| bat_present | input | 1 | Battery present flag |
| bat_above_hi | input | 1 | Battery weaker than the upper threshold |
| bat_below_lo | input | 1 | Battery stronger than the lower threshold |
| ring_zc | input | 1 | Ringing-current zero-crossing flag |
| sw_break | output | 1 | Break pair enable |
| sw_ring | output | 1 | Ringing pair enable |
| sw_tout | output | 1 | Test-out pair enable |
| sw_tin | output | 1 | Test-in pair enable |
| sw_rtest | output | 1 | Ringing-test pair enable |
| sd_pin_level | output | 1 | Sensed level of the shutdown pin |

## Verification
Each result has a fixed latency. A mode or hold change appears one clock after the edge that samples it. A pin or temperature change appears after three clocks, and a battery flag change after four clocks, because of the two-flop synchroniser and the fault register. The directed checks drive inputs on a falling edge. They sample at the falling edge one cycle before the due cycle to confirm the old value, then at the due cycle to confirm the new one. The random steps first settle the synchronised inputs with zero crossings allowed, then change the mode. Their expected values are therefore steady-state values from a bench model of latch, fault and ringing-hold state.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  localparam int MODE_W = 3;

  // switch pair enables
  typedef struct packed {
    logic brk;
    logic ring;
    logic tout;
    logic tin;
    logic rtest;
  } grp_t;

  // code bits: [2] ringing, [1] test-in, [0] test-out
  function automatic grp_t decode_mode(input logic [MODE_W-1:0] code, input bit ext);
    grp_t g;
    g = '0;
    case (code)
      3'b000: g.brk = 1'b1;
      3'b001: g.tout = 1'b1;
      3'b010: g.tin = 1'b1;
      3'b011: begin
        g.tin  = 1'b1;
        g.tout = 1'b1;
      end
      3'b100: g.ring = 1'b1;
      3'b110: begin
        g.rtest = 1'b1;
        g.tout  = ext;
      end
      default: g = '0;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/lsc_sync.sv
module lsc_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/lsc_mode_latch.sv
module lsc_mode_latch #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic [W-1:0] mode_in,
  output logic [W-1:0] mode_eff
);

  logic [W-1:0] cap_q;

  // transparent while hold is low, frozen copy while high
  assign mode_eff = hold ? cap_q : mode_in;

  always_ff @(posedge clk) begin
    if (rst) cap_q <= '0;
    else     cap_q <= mode_eff;
  end

endmodule

// File: rtl/lsc_batt_mon.sv
module lsc_batt_mon (
  input  logic clk,
  input  logic rst,
  input  logic present,
  input  logic above_hi,
  input  logic below_lo,
  output logic fault
);

  logic fault_q;

  always_ff @(posedge clk) begin
    if (rst)                       fault_q <= 1'b1;
    else if (!present || above_hi) fault_q <= 1'b1;
    else if (below_lo)             fault_q <= 1'b0;
  end

  assign fault = fault_q;

endmodule

// File: rtl/lsc_switch_drv.sv
module lsc_switch_drv
  import lsc_pkg::*;
#(
  parameter bit EXTENDED = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_eff,
  input  logic              force_off,
  input  logic              ring_zc,
  output grp_t              grp
);

  grp_t tgt;
  grp_t grp_q;

  always_comb begin
    tgt = decode_mode(mode_eff, EXTENDED);
    if (force_off) tgt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_q <= '0;
    end else begin
      grp_q.brk   <= tgt.brk;
      grp_q.tout  <= tgt.tout;
      grp_q.tin   <= tgt.tin;
      grp_q.rtest <= tgt.rtest;
      // ringing pair releases only at a current zero crossing
      grp_q.ring  <= tgt.ring | (grp_q.ring & ~ring_zc);
    end
  end

  assign grp = grp_q;

endmodule

// File: rtl/line_switch_ctrl.sv
module line_switch_ctrl
  import lsc_pkg::*;
#(
  parameter bit EXTENDED    = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_ring,
  input  logic mode_tin,
  input  logic mode_tout,
  input  logic hold_en,
  input  logic ovr_low,
  input  logic ovr_high,
  input  logic over_temp,
  input  logic bat_present,
  input  logic bat_above_hi,
  input  logic bat_below_lo,
  input  logic ring_zc,
  output logic sw_break,
  output logic sw_ring,
  output logic sw_tout,
  output logic sw_tin,
  output logic sw_rtest,
  output logic sd_pin_level
);

  localparam int ASYNC_W = 6;

  logic [ASYNC_W-1:0] async_raw;
  logic [ASYNC_W-1:0] async_s;
  logic               ovr_low_s, ovr_high_s, temp_s;
  logic               bpres_s, bhi_s, blo_s;
  logic [MODE_W-1:0]  mode_eff;
  logic               bat_fault;
  logic               tsd_act;
  logic               force_off;
  logic               pin_q;
  grp_t               grp;

  assign async_raw = {ovr_low, ovr_high, over_temp, bat_present, bat_above_hi, bat_below_lo};

  lsc_sync #(.WIDTH(ASYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (async_raw),
    .dout(async_s)
  );

  assign {ovr_low_s, ovr_high_s, temp_s, bpres_s, bhi_s, blo_s} = async_s;

  lsc_mode_latch #(.W(MODE_W)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .hold    (hold_en),
    .mode_in ({mode_ring, mode_tin, mode_tout}),
    .mode_eff(mode_eff)
  );

  lsc_batt_mon u_batt (
    .clk     (clk),
    .rst     (rst),
    .present (bpres_s),
    .above_hi(bhi_s),
    .below_lo(blo_s),
    .fault   (bat_fault)
  );

  // thermal shutdown is disabled while the pin is held high
  assign tsd_act   = temp_s & ~ovr_high_s;
  assign force_off = ovr_low_s | tsd_act | bat_fault;

  lsc_switch_drv #(.EXTENDED(EXTENDED)) u_drv (
    .clk      (clk),
    .rst      (rst),
    .mode_eff (mode_eff),
    .force_off(force_off),
    .ring_zc  (ring_zc),
    .grp      (grp)
  );

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b1;
    else     pin_q <= ~(ovr_low_s | tsd_act);
  end

  assign sw_break     = grp.brk;
  assign sw_ring      = grp.ring;
  assign sw_tout      = grp.tout;
  assign sw_tin       = grp.tin;
  assign sw_rtest     = grp.rtest;
  assign sd_pin_level = pin_q;

endmodule

// File: rtl/line_switch_ctrl_chk.sv
module line_switch_ctrl_chk #(
  parameter bit EXTENDED = 1'b0
) (
  input logic clk,
  input logic rst,
  input logic ovr_low,
  input logic ring_zc,
  input logic sw_break,
  input logic sw_ring,
  input logic sw_tout,
  input logic sw_tin,
  input logic sw_rtest,
  input logic sd_pin_level
);

  AST_BREAK_EXCL: assert property (@(posedge clk) disable iff (rst)
    sw_break |-> !(sw_tout || sw_tin || sw_rtest)); // R1

  AST_TIN_RTEST_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(sw_tin && sw_rtest)); // R1

  AST_BASE_NO_TOUT_RTEST: assert property (@(posedge clk) disable iff (rst)
    (EXTENDED == 1'b0) |-> !(sw_tout && sw_rtest)); // R2

  AST_RING_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sw_ring && !ring_zc) |=> sw_ring); // R7

  AST_OVR_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    (ovr_low && $past(ovr_low) && $past(ovr_low, 2) && !$past(rst) && !$past(rst, 2))
    |=> !(sw_break || sw_tout || sw_tin || sw_rtest)); // R4

  AST_OVR_PIN_LOW: assert property (@(posedge clk) disable iff (rst)
    (ovr_low && $past(ovr_low) && $past(ovr_low, 2) && !$past(rst) && !$past(rst, 2))
    |=> !sd_pin_level); // R4

endmodule

bind line_switch_ctrl line_switch_ctrl_chk #(.EXTENDED(EXTENDED)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ovr_low     (ovr_low),
  .ring_zc     (ring_zc),
  .sw_break    (sw_break),
  .sw_ring     (sw_ring),
  .sw_tout     (sw_tout),
  .sw_tin      (sw_tin),
  .sw_rtest    (sw_rtest),
  .sd_pin_level(sd_pin_level)
);

// File: tb/test_line_switch_ctrl.sv
module test_line_switch_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] mode = 3'b000;
  logic hold_en = 1'b0, ovr_low = 1'b0, ovr_high = 1'b0, over_temp = 1'b0;
  logic bat_present = 1'b1, bat_above_hi = 1'b0, bat_below_lo = 1'b1, ring_zc = 1'b0;
  logic b_brk, b_ring, b_tout, b_tin, b_rtest, b_pin;
  logic e_brk, e_ring, e_tout, e_tin, e_rtest, e_pin;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  line_switch_ctrl #(.EXTENDED(1'b0)) i_line_switch_ctrl (
    .clk(clk), .rst(rst), .mode_ring(mode[2]), .mode_tin(mode[1]), .mode_tout(mode[0]),
    .hold_en(hold_en), .ovr_low(ovr_low), .ovr_high(ovr_high), .over_temp(over_temp),
    .bat_present(bat_present), .bat_above_hi(bat_above_hi), .bat_below_lo(bat_below_lo),
    .ring_zc(ring_zc), .sw_break(b_brk), .sw_ring(b_ring), .sw_tout(b_tout),
    .sw_tin(b_tin), .sw_rtest(b_rtest), .sd_pin_level(b_pin));

  line_switch_ctrl #(.EXTENDED(1'b1)) i_line_switch_ctrl_ext (
    .clk(clk), .rst(rst), .mode_ring(mode[2]), .mode_tin(mode[1]), .mode_tout(mode[0]),
    .hold_en(hold_en), .ovr_low(ovr_low), .ovr_high(ovr_high), .over_temp(over_temp),
    .bat_present(bat_present), .bat_above_hi(bat_above_hi), .bat_below_lo(bat_below_lo),
    .ring_zc(ring_zc), .sw_break(e_brk), .sw_ring(e_ring), .sw_tout(e_tout),
    .sw_tin(e_tin), .sw_rtest(e_rtest), .sd_pin_level(e_pin));

  // expected vector {brk, ring, tout, tin, rtest, pin}
  function automatic logic [5:0] expect_vec(input logic [2:0] code, input bit ext,
                                            input bit off, input bit ring, input bit pin);
    logic [4:0] g;
    case (code)
      3'b000: g = 5'b10000;
      3'b001: g = 5'b00100;
      3'b010: g = 5'b00010;
      3'b011: g = 5'b00110;
      3'b100: g = 5'b01000;
      3'b110: g = ext ? 5'b00101 : 5'b00001;
      default: g = 5'b00000;
    endcase
    if (off) g = 5'b00000;
    g[3] = ring;
    return {g, pin};
  endfunction

  function automatic bit ring_cmd(input logic [2:0] code, input bit off);
    return (code == 3'b100) && !off;
  endfunction

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [5:0] base_out();
    return {b_brk, b_ring, b_tout, b_tin, b_rtest, b_pin};
  endfunction

  function automatic logic [5:0] ext_out();
    return {e_brk, e_ring, e_tout, e_tin, e_rtest, e_pin};
  endfunction

  initial begin
    logic [2:0] cap, prev_cap;
    bit fault, force_off, tsd, ring_m, pin;
    void'($urandom(32'd20240611));

    // R8: reset state
    wait_n(3);
    chk("R8 reset all open, pin high", base_out(), 6'b000001);
    @(negedge clk) rst = 1'b0;
    wait_n(1);
    chk("R8 battery fault set after reset", base_out(), 6'b000001);
    wait_n(6);
    chk("R8 idle after battery settles", base_out(), 6'b100001);

    // R9 and R1: one-cycle mode latency, walk of all codes with zero crossings
    ring_zc = 1'b1;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk) mode = 3'(c);
      wait_n(1);
      chk($sformatf("R1 R9 base code %0d", c), base_out(),
          expect_vec(3'(c), 1'b0, 1'b0, c == 4, 1'b1));
      chk($sformatf("R2 ext code %0d", c), ext_out(),
          expect_vec(3'(c), 1'b1, 1'b0, c == 4, 1'b1));
    end

    // R7: make-before-break with ringing hold
    @(negedge clk) begin mode = 3'b100; ring_zc = 1'b0; end
    wait_n(2);
    @(negedge clk) mode = 3'b000;
    wait_n(1);
    chk("R7 break closed while ringing held", base_out(), 6'b110001);
    wait_n(3);
    chk("R7 ringing still held without zero cross", base_out(), 6'b110001);
    ring_zc = 1'b1;
    @(negedge clk) ring_zc = 1'b0;
    chk("R7 ringing released at zero cross", base_out(), 6'b100001);

    // R7: break-before-make via all-off code
    @(negedge clk) mode = 3'b100;
    wait_n(1);
    @(negedge clk) mode = 3'b101;
    wait_n(2);
    chk("R7 all-off code keeps ringing until zero cross", base_out(), 6'b010001);
    ring_zc = 1'b1;
    @(negedge clk) begin ring_zc = 1'b0; mode = 3'b000; end
    chk("R7 ringing opened, nothing closed", base_out(), 6'b000001);
    wait_n(1);
    chk("R7 break closes after release", base_out(), 6'b100001);

    // R3: hold latch
    ring_zc = 1'b1;
    @(negedge clk) mode = 3'b001;
    wait_n(1);
    @(negedge clk) begin hold_en = 1'b1; mode = 3'b010; end
    wait_n(1);
    chk("R3 frozen at last open-latch code", base_out(), 6'b001001);
    @(negedge clk) mode = 3'b100;
    wait_n(3);
    chk("R3 input change ignored while held", base_out(), 6'b001001);
    @(negedge clk) hold_en = 1'b0;
    wait_n(1);
    chk("R3 pass-through after release", base_out(), 6'b010001);
    @(negedge clk) mode = 3'b000;
    wait_n(2);

    // R4 and R9: pin override, three-cycle latency, also while held
    @(negedge clk) begin hold_en = 1'b1; ovr_low = 1'b1; end
    wait_n(2);
    chk("R9 override not yet active", base_out(), 6'b100001);
    wait_n(1);
    chk("R4 override opens all, pin low", base_out(), 6'b000000);
    @(negedge clk) ovr_low = 1'b0;
    wait_n(3);
    chk("R4 control returns after override", base_out(), 6'b100001);
    hold_en = 1'b0;

    // R5: thermal shutdown and its disable
    @(negedge clk) over_temp = 1'b1;
    wait_n(3);
    chk("R5 thermal opens all, pin low", base_out(), 6'b000000);
    @(negedge clk) ovr_high = 1'b1;
    wait_n(3);
    chk("R5 pin high ignores thermal", base_out(), 6'b100001);
    @(negedge clk) begin ovr_high = 1'b0; over_temp = 1'b0; end
    wait_n(4);

    // R6 and R9: battery hysteresis with four-cycle latency
    @(negedge clk) begin bat_above_hi = 1'b1; bat_below_lo = 1'b0; end
    wait_n(3);
    chk("R9 battery fault not yet active", base_out(), 6'b100001);
    wait_n(1);
    chk("R6 weak battery opens all", base_out(), 6'b000001);
    @(negedge clk) bat_above_hi = 1'b0;
    wait_n(8);
    chk("R6 fault held between thresholds", base_out(), 6'b000001);
    @(negedge clk) bat_below_lo = 1'b1;
    wait_n(4);
    chk("R6 fault cleared below lower threshold", base_out(), 6'b100001);
    @(negedge clk) bat_present = 1'b0;
    wait_n(4);
    chk("R6 missing battery opens all", base_out(), 6'b000001);
    @(negedge clk) bat_present = 1'b1;
    wait_n(5);
    chk("R6 battery return restores", base_out(), 6'b100001);

    // random steps against a bench model
    cap = 3'b000; fault = 1'b0; ring_m = 1'b0;
    for (int s = 0; s < 300; s++) begin
      @(negedge clk) begin
        ovr_low      = ($urandom % 10) == 0;
        ovr_high     = !ovr_low && (($urandom % 5) == 0);
        over_temp    = ($urandom % 7) == 0;
        bat_present  = ($urandom % 20) != 0;
        bat_above_hi = ($urandom % 10) == 0;
        bat_below_lo = ($urandom % 10) < 7;
        ring_zc      = 1'b1;
      end
      if (!bat_present || bat_above_hi) fault = 1'b1;
      else if (bat_below_lo)            fault = 1'b0;
      tsd       = over_temp && !ovr_high;
      force_off = ovr_low || tsd || fault;
      pin       = !(ovr_low || tsd);
      ring_m    = ring_cmd(cap, force_off);
      wait_n(5);
      prev_cap = cap;
      @(negedge clk) begin
        mode    = 3'($urandom % 8);
        hold_en = ($urandom % 4) == 0;
        ring_zc = ($urandom % 2) == 1;
      end
      if (!hold_en) cap = mode;
      ring_m = ring_cmd(cap, force_off) || (ring_m && !ring_zc);
      wait_n(3);
      chk($sformatf("R1 R3 R4 R5 R6 R7 random base step %0d from %0d", s, prev_cap), base_out(),
          expect_vec(cap, 1'b0, force_off, ring_m, pin));
      chk($sformatf("R2 random ext step %0d", s), ext_out(),
          expect_vec(cap, 1'b1, force_off, ring_m, pin));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule